// File: doc/BRIEF.md
# Selectable-Source Reference Strobe Divider

This block derives two peripheral reference clock-enable strobes inside a single clock domain. Three source stages stand in for frequency synthesizers. Each stage receives a one-cycle tick strobe and its own stage control word. A stage either forwards its tick or is halted. Forced bypass always forwards the tick, and a set reset or power-down bit halts the stage. Multiplication is not modelled: a running stage passes its stand-in tick unchanged.

A clock-control register picks one of the three stage outputs through a 2-bit selector and divides it by a 6-bit divisor. Each output strobe has its own enable bit and its own divide counter. A counter restarts cleanly whenever the divisor or the selector changes, when its own enable changes, or when the selected stage starts or stops. A host loads the register through a single-cycle write strobe and can read it back.

A tick at a stage input passes through one stage register and one divider register. The resulting strobe is therefore high in the second cycle after the cycle in which the tick was applied.

Top module: `src_div_strobe`

## Requirements
- R1: While `rst_n` is low and after every reset, `ctl_value` reads 0x00003F03. That value means enable bits [1:0] = 11, selector [5:4] = 00 and divisor [13:8] = 63. All other bits of `ctl_value` read as zero.
- R2: Stage control bit 4 set (forced bypass) forwards the stage tick, even when bit 0 or bit 1 is also set.
- R3: With bit 4 clear, a set bit 0 (reset) or a set bit 1 (power-down) halts the stage, so no tick from it is counted.
- R4: Stage control bits 18:12 (feedback field), bits 3:2 and all other unnamed bits have no effect on the strobes.
- R5: Selector values 0 and 1 pick stage 0 (I/O). Value 2 picks stage 1 (CPU) and value 3 picks stage 2 (memory). Ticks of the other stages are not counted.
- R6: With divisor N ≥ 1, an enabled output emits one strobe for every N counted ticks of the selected stage. A tick applied in cycle t gives a strobe that is high in cycle t+2, and the strobe lasts one cycle.
- R7: A divisor of 0 divides by 1, so every counted tick gives a strobe.
- R8: Bit 0 of the clock-control word enables `ref_stb[0]` and bit 1 enables `ref_stb[1]`. The two enables act independently, and an output whose bit is clear stays low.
- R9: A write to the clock-control register restarts the count of an output if it changes the selector, the divisor or that output's enable bit. A tick that reaches the divider in the write cycle is dropped. A disabled output is low from the cycle after the write, and a re-enabled output begins a fresh divide period.
- R10: When the selected stage starts or stops, both counts restart, and the tick that coincides with the change is dropped.
- R11: A low `rst_n` forces both strobes low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 3 | Tick strobes of the stages; bit 0 I/O, bit 1 CPU, bit 2 memory |
| stage_ctl | input | 3x32 | Control word per stage, index matches `src_tick` |
| ctl_wr_en | input | 1 | Loads `ctl_wr_data` into the clock-control register |
| ctl_wr_data | input | 32 | New clock-control word |
| ctl_value | output | 32 | Current clock-control word |
| ref_stb | output | 2 | Divided reference strobes |

## Verification
The hardest situation to reach is a restart that lands in the middle of a partial count while a tick arrives in the same cycle. Such a restart comes either from a divisor rewrite or from halting and resuming the selected stage. The stimulus leaves a count part-way, then issues the write together with a tick, or toggles the stage's power-down bit. It then counts out a full period, so that a counter that kept stale state or counted the dropped tick produces a strobe in the wrong cycle. A reference model inside the driver predicts every cycle's strobe pair, and the monitor compares each pair in order.

// File: rtl/sds_pkg.sv
package sds_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_SRC = 3;
  localparam int NUM_OUT = 2;
  localparam int SEL_W   = 2;
  localparam int DIV_W   = 6;

  // stage control word positions
  localparam int STG_RST_BIT = 0;
  localparam int STG_PD_BIT  = 1;
  localparam int STG_BYP_BIT = 4;

  // clock-control word positions
  localparam int CTL_EN_LSB  = 0;
  localparam int CTL_SEL_LSB = 4;
  localparam int CTL_DIV_LSB = 8;
  localparam logic [WORD_W-1:0] CTL_RESET = 32'h0000_3F03;

  typedef enum logic [1:0] {
    SRC_IO  = 2'd0,
    SRC_CPU = 2'd1,
    SRC_MEM = 2'd2
  } src_e;

  typedef struct packed {
    logic [DIV_W-1:0]   div;
    logic [SEL_W-1:0]   sel;
    logic [NUM_OUT-1:0] en;
  } clk_cfg_t;

  function automatic clk_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
    clk_cfg_t c;
    c.div = w[CTL_DIV_LSB +: DIV_W];
    c.sel = w[CTL_SEL_LSB +: SEL_W];
    c.en  = w[CTL_EN_LSB  +: NUM_OUT];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] pack_cfg(input clk_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CTL_DIV_LSB +: DIV_W]   = c.div;
    w[CTL_SEL_LSB +: SEL_W]   = c.sel;
    w[CTL_EN_LSB  +: NUM_OUT] = c.en;
    return w;
  endfunction

  function automatic src_e src_of_sel(input logic [SEL_W-1:0] sel);
    src_e s;
    case (sel)
      2'd2:    s = SRC_CPU;
      2'd3:    s = SRC_MEM;
      default: s = SRC_IO;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sds_src_stage.sv
module sds_src_stage
  import sds_pkg::*;
#(
  parameter int CW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic [CW-1:0] ctl,
  output logic          tick_q,
  output logic          chg_q
);
  logic run_d, run_q;
  logic tick_d, chg_d;
  logic unused_ctl;

  assign unused_ctl = ^{ctl[CW-1:STG_BYP_BIT+1], ctl[STG_BYP_BIT-1:STG_PD_BIT+1]};

  // bypass wins over reset and power-down
  always_comb begin
    if (ctl[STG_BYP_BIT]) run_d = 1'b1;
    else                  run_d = !(ctl[STG_RST_BIT] || ctl[STG_PD_BIT]);
    tick_d = run_d & tick_in;
    chg_d  = run_d ^ run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tick_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      tick_q <= tick_d;
      chg_q  <= chg_d;
    end
  end
endmodule

// File: rtl/sds_src_mux.sv
module sds_src_mux
  import sds_pkg::*;
#(
  parameter int NS = NUM_SRC
) (
  input  logic [NS-1:0]    tick,
  input  logic [NS-1:0]    chg,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_o,
  output logic             chg_o
);
  src_e idx;

  always_comb begin
    idx    = src_of_sel(sel);
    tick_o = tick[idx];
    chg_o  = chg[idx];
  end
endmodule

// File: rtl/sds_ctl_reg.sv
module sds_ctl_reg
  import sds_pkg::*;
#(
  parameter int CW = WORD_W,
  parameter int NO = NUM_OUT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output clk_cfg_t      cfg_q,
  output logic [NO-1:0] restart
);
  clk_cfg_t cfg_new, cfg_d;
  logic     cfg_ld;
  logic     unused_wr;

  assign unused_wr = ^wr_data;

  always_comb begin
    cfg_new = unpack_cfg(wr_data);
    cfg_ld  = wr_en;
    cfg_d   = cfg_ld ? cfg_new : cfg_q;
    for (int i = 0; i < NO; i++) begin
      restart[i] = wr_en && ((cfg_new.sel != cfg_q.sel) ||
                             (cfg_new.div != cfg_q.div) ||
                             (cfg_new.en[i] != cfg_q.en[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= unpack_cfg(CTL_RESET);
    else if (cfg_ld) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/sds_divider.sv
module sds_divider #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          restart,
  input  logic          tick,
  input  logic [DW-1:0] div,
  output logic          stb_q
);
  logic [DW-1:0] cnt_q, cnt_d, term;
  logic          stb_d;

  always_comb begin
    term  = (div == '0) ? '0 : div - 1'b1;
    cnt_d = cnt_q;
    stb_d = 1'b0;
    if (restart || !en) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == term) begin
        cnt_d = '0;
        stb_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end
endmodule

// File: rtl/src_div_strobe.sv
module src_div_strobe
  import sds_pkg::*;
#(
  parameter int WORD_W_P  = WORD_W,
  parameter int NUM_SRC_P = NUM_SRC,
  parameter int NUM_OUT_P = NUM_OUT
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_SRC_P-1:0]               src_tick,
  input  logic [NUM_SRC_P-1:0][WORD_W_P-1:0] stage_ctl,
  input  logic                               ctl_wr_en,
  input  logic [WORD_W_P-1:0]                ctl_wr_data,
  output logic [WORD_W_P-1:0]                ctl_value,
  output logic [NUM_OUT_P-1:0]               ref_stb
);
  logic [NUM_SRC_P-1:0] stg_tick, stg_chg;
  logic                 mux_tick, mux_chg;
  clk_cfg_t             cfg_q;
  logic [NUM_OUT_P-1:0] ctl_restart;

  for (genvar s = 0; s < NUM_SRC_P; s++) begin : g_stage
    sds_src_stage #(.CW(WORD_W_P)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_in (src_tick[s]),
      .ctl     (stage_ctl[s]),
      .tick_q  (stg_tick[s]),
      .chg_q   (stg_chg[s])
    );
  end

  sds_src_mux #(.NS(NUM_SRC_P)) u_mux (
    .tick   (stg_tick),
    .chg    (stg_chg),
    .sel    (cfg_q.sel),
    .tick_o (mux_tick),
    .chg_o  (mux_chg)
  );

  sds_ctl_reg #(.CW(WORD_W_P), .NO(NUM_OUT_P)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .cfg_q   (cfg_q),
    .restart (ctl_restart)
  );

  for (genvar i = 0; i < NUM_OUT_P; i++) begin : g_out
    sds_divider #(.DW(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cfg_q.en[i]),
      .restart (ctl_restart[i] | mux_chg),
      .tick    (mux_tick),
      .div     (cfg_q.div),
      .stb_q   (ref_stb[i])
    );
  end

  assign ctl_value = pack_cfg(cfg_q);
endmodule

// File: rtl/src_div_strobe_chk.sv
module src_div_strobe_chk
  import sds_pkg::*;
#(
  parameter int CW = WORD_W,
  parameter int NO = NUM_OUT
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr_en,
  input logic [CW-1:0] ctl_wr_data,
  input logic [CW-1:0] ctl_value,
  input logic [NO-1:0] ref_stb,
  input logic          mux_tick
);
  logic unused_chk;
  assign unused_chk = ^{ctl_wr_data, ctl_value};

  for (genvar i = 0; i < NO; i++) begin : g_a
    // R8: a strobe only while its enable bit is set
    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ref_stb[i] |-> ctl_value[CTL_EN_LSB + i]);

    // R6: with N >= 2 strobes never come back to back
    assert_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_stb[i] && (ctl_value[CTL_DIV_LSB +: DIV_W] > 6'd1)) |=> !ref_stb[i]);

    // R5: every strobe follows a tick of the selected stage
    assert_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ref_stb[i] |-> $past(mux_tick));
  end

  // R9: a divisor rewrite silences both outputs in the following cycle
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && (ctl_wr_data[CTL_DIV_LSB +: DIV_W] != ctl_value[CTL_DIV_LSB +: DIV_W]))
    |=> (ref_stb == '0));
endmodule

bind src_div_strobe src_div_strobe_chk #(.CW(WORD_W_P), .NO(NUM_OUT_P)) u_chk (.*);

// File: tb/src_div_strobe_tb.sv
module src_div_strobe_tb;
  logic              clk;
  logic              rst_n;
  logic [2:0]        src_tick;
  logic [2:0][31:0]  stage_ctl;
  logic              ctl_wr_en;
  logic [31:0]       ctl_wr_data;
  logic [31:0]       ctl_value;
  logic [1:0]        ref_stb;

  src_div_strobe u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .stage_ctl(stage_ctl),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_value(ctl_value), .ref_stb(ref_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [1:0] exp;
    string      tag;
  } item_t;

  item_t            sbq[$];
  int               checks = 0;
  int               fails  = 0;
  bit               done   = 0;
  logic [2:0][31:0] stg_next;

  // reference model state
  bit m_tq[3];
  bit m_chg[3];
  bit m_prev[3];
  int m_cnt[2];
  int m_en, m_sel, m_div;

  task automatic model_init();
    for (int s = 0; s < 3; s++) begin
      m_tq[s] = 0; m_chg[s] = 0; m_prev[s] = 0;
    end
    m_cnt[0] = 0; m_cnt[1] = 0;
    m_en = 3; m_sel = 0; m_div = 63;
  endtask

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_word(int en, int sel, int div);
    logic [31:0] w;
    w = '0;
    w[1:0]  = en[1:0];
    w[5:4]  = sel[1:0];
    w[13:8] = div[5:0];
    return w;
  endfunction

  // drive one cycle, predict the strobes after the coming edge
  task automatic cyc(input logic [2:0] tk, input bit wr, input logic [31:0] wd,
                     input string tag, input bit rst_mid = 0);
    item_t it;
    int    sidx, n, nen, nsel, ndiv;
    bit    rs, run;
    stage_ctl   = stg_next;
    src_tick    = tk;
    ctl_wr_en   = wr;
    ctl_wr_data = wd;
    nen = int'(wd[1:0]); nsel = int'(wd[5:4]); ndiv = int'(wd[13:8]);
    sidx = (m_sel <= 1) ? 0 : m_sel - 1;
    n    = (m_div == 0) ? 1 : m_div;
    for (int i = 0; i < 2; i++) begin
      rs = (wr && (nsel != m_sel || ndiv != m_div || ((nen >> i) & 1) != ((m_en >> i) & 1)))
           || m_chg[sidx] || (((m_en >> i) & 1) == 0);
      it.exp[i] = 1'b0;
      if (rs) m_cnt[i] = 0;
      else if (m_tq[sidx]) begin
        if (m_cnt[i] == n - 1) begin m_cnt[i] = 0; it.exp[i] = 1'b1; end
        else m_cnt[i]++;
      end
    end
    for (int s = 0; s < 3; s++) begin
      run = stg_next[s][4] || !(stg_next[s][0] || stg_next[s][1]);
      m_chg[s]  = (run != m_prev[s]);
      m_prev[s] = run;
      m_tq[s]   = tk[s] && run;
    end
    if (wr) begin m_en = nen; m_sel = nsel; m_div = ndiv; end
    it.tag = tag;
    sbq.push_back(it);
    @(posedge clk);
    if (rst_mid) begin
      #2 rst_n = 1'b0;
      #1;
      chk(ref_stb == 2'b00, "R11", "strobes at async reset", ref_stb, 0);
      chk(ctl_value == 32'h3F03, "R1", "ctl_value at async reset", ctl_value, 32'h3F03);
    end
    @(negedge clk);
  endtask

  task automatic burst(int cycles, logic [2:0] mask, int every, string tag);
    for (int c = 0; c < cycles; c++) cyc((c % every == 0) ? mask : 3'b000, 0, '0, tag);
  endtask

  task automatic wcfg(int en, int sel, int div, string tag);
    cyc(3'b000, 1, cfg_word(en, sel, div), tag);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    item_t it;
    #1;
    if (rst_n && sbq.size() > 0) begin
      it = sbq.pop_front();
      for (int i = 0; i < 2; i++)
        chk(ref_stb[i] == it.exp[i], it.tag, $sformatf("ref_stb[%0d]", i), ref_stb[i], it.exp[i]);
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_tick = '0; ctl_wr_en = 1'b0; ctl_wr_data = '0;
    stg_next = '0; stage_ctl = '0;
    model_init();
    repeat (3) @(negedge clk);
    chk(ref_stb == 2'b00, "R11", "strobes in reset", ref_stb, 0);
    chk(ctl_value == 32'h3F03, "R1", "ctl_value in reset", ctl_value, 32'h3F03);
    rst_n = 1'b1;

    // R1 / R6: default divide by 63 on both outputs
    burst(70, 3'b001, 1, "R1");
    chk(ctl_value == 32'h3F03, "R1", "ctl_value after run", ctl_value, 32'h3F03);

    // R6: divide by 3 with dense and sparse ticks
    wcfg(3, 0, 3, "R9");
    burst(12, 3'b001, 1, "R6");
    burst(14, 3'b001, 2, "R6");

    // R7: zero divisor means every tick
    wcfg(3, 0, 0, "R7");
    burst(9, 3'b001, 2, "R7");
    burst(4, 3'b001, 1, "R7");

    // R5: selector mapping
    wcfg(3, 2, 2, "R5");
    burst(8, 3'b010, 1, "R5");
    burst(8, 3'b101, 1, "R5");
    wcfg(3, 3, 2, "R5");
    burst(8, 3'b100, 1, "R5");
    burst(8, 3'b011, 1, "R5");
    wcfg(3, 1, 2, "R5");
    burst(8, 3'b001, 1, "R5");
    burst(8, 3'b110, 1, "R5");
    chk(ctl_value == 32'h0213, "R5", "ctl_value readback", ctl_value, 32'h0213);

    // R8: independent enables
    wcfg(1, 0, 2, "R8");
    burst(9, 3'b001, 1, "R8");
    wcfg(2, 0, 2, "R8");
    burst(9, 3'b001, 1, "R8");
    wcfg(0, 0, 2, "R8");
    burst(6, 3'b001, 1, "R8");
    wcfg(3, 0, 2, "R8");
    burst(5, 3'b001, 1, "R8");

    // R9: rewrite mid-count with a tick in the write cycle, and disable with a tick
    wcfg(3, 0, 4, "R9");
    burst(3, 3'b001, 1, "R9");
    cyc(3'b001, 1, cfg_word(3, 0, 5), "R9");
    burst(13, 3'b001, 1, "R9");
    burst(3, 3'b001, 1, "R9");
    cyc(3'b001, 1, cfg_word(2, 0, 5), "R9");
    burst(8, 3'b001, 1, "R9");
    wcfg(3, 0, 5, "R9");
    burst(8, 3'b001, 1, "R9");

    // R3 / R2 / R4: stage halts, bypass priority, ignored fields
    wcfg(3, 0, 1, "R3");
    stg_next[0] = 32'h0000_0001;
    burst(8, 3'b001, 1, "R3");
    stg_next[0] = 32'h0000_0002;
    burst(8, 3'b001, 1, "R3");
    stg_next[0] = 32'h0000_0013;
    burst(8, 3'b001, 1, "R2");
    stg_next[0] = 32'hFFF7_F01C;
    burst(8, 3'b001, 2, "R2");
    stg_next[0] = 32'h0007_F00C;
    burst(8, 3'b001, 1, "R4");
    stg_next[1] = 32'h0000_0003;
    burst(6, 3'b011, 1, "R4");
    stg_next[1] = '0;
    stg_next[0] = '0;
    burst(4, 3'b000, 1, "R4");

    // R10: halt and resume the selected stage mid-count
    wcfg(3, 0, 5, "R10");
    burst(3, 3'b001, 1, "R10");
    stg_next[0] = 32'h0000_0002;
    burst(3, 3'b001, 1, "R10");
    stg_next[0] = '0;
    burst(14, 3'b001, 1, "R10");

    // R11: asynchronous reset while a strobe is high
    wcfg(3, 0, 0, "R11");
    cyc(3'b001, 0, '0, "R11");
    cyc(3'b000, 0, '0, "R11", 1);
    sbq.delete();
    model_init();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    burst(68, 3'b001, 1, "R1");
    burst(3, 3'b000, 1, "R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule